// File: doc/BRIEF.md
# Converter Register Bank with Offset Correction

This block sits between a 14-bit data converter and a host. The host reaches four 14-bit registers through a synchronous write strobe, a 2-bit address and a combinational read path. The registers are the latched conversion result, the amplifier gain code, a signed DC offset and a control word. Raw samples come in on a converter-side valid/data port. Each accepted sample can have the signed offset added, with saturation. It is then recoded as unsigned binary or two's complement and latched as the result the host reads. A write with bit 0 set to the result address is a software reset of the settings registers.

Power is handled by a two-state machine. `PWR_ACTIVE` is entered from hardware reset and accepts samples. The transition *enter_sleep* (`PWR_ACTIVE` to `PWR_SLEEP`) fires on a control write with bit 13 set and no software reset on the same edge. `PWR_SLEEP` ignores samples. The transition *wake* (`PWR_SLEEP` to `PWR_ACTIVE`) fires on a control write with bit 13 clear, or on a software reset. The state is the power-down bit in control readback and drives the `pwr_down` output. Reference select, test-mode code and a test-active flag are exported from the control word.

Top module: `adc_conv_regbank`

## Requirements
- R1: Register selection by `host_addr` is 0 = result, 1 = gain (bits 2..0), 2 = offset (bits 7..0), 3 = control. The control word is laid out as bit 13 power-down, bit 12 reference select, bit 11 output format, bits 10..8 test mode and bit 7 offset enable. `host_rdata` shows the selected register in the same cycle, and any unimplemented or reserved bit reads 0.
- R2: While `rst_n` is low, all four registers clear to 0 and the power state is `PWR_ACTIVE`.
- R3: A write to address 0 with bit 0 set clears gain, offset and control (including power state) on that edge. A write to address 0 with bit 0 clear changes nothing.
- R4: Host writes never alter the result register.
- R5: `gain_code` equals the stored 3-bit gain code.
- R6: With offset enable and format both 0, an accepted sample is stored unchanged.
- R7: With offset enable set, the 8-bit two's-complement offset (-128..+127) is added to the unsigned sample before storage.
- R8: The offset sum saturates at 0x0000 and 0x3FFF in the unsigned domain instead of wrapping.
- R9: With format set, bit 13 of the saturated value is inverted. Saturated results therefore read 0x2000 (minimum) and 0x1FFF (maximum).
- R10: In `PWR_SLEEP`, `pwr_down` is 1, samples are ignored and the result holds its value. After *wake*, samples are accepted again.
- R11: `ref_sel` and `test_mode` follow control bits 12 and 10..8. `test_active` is 0 for test codes 0 and 4 and 1 for the other six codes.
- R12: A sample accepted on the same edge as a settings write is processed with the settings in force before that edge. The result is readable from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 14 | Host write data |
| host_rdata | output | 14 | Selected register contents |
| smp_valid | input | 1 | Raw sample present |
| smp_data | input | 14 | Raw unsigned sample |
| gain_code | output | 3 | Amplifier gain code, 1 dB per step |
| pwr_down | output | 1 | Power state is `PWR_SLEEP` |
| ref_sel | output | 1 | Reference select (1 = external) |
| test_mode | output | 3 | Test-mode code |
| test_active | output | 1 | A non-normal test code is selected |

## Verification
The hardest situation to reach is the same-edge collision. In it, a settings write and a sample land on one clock edge, and the result must show the old format and offset while the registers already hold the new ones. The stimulus raises the write strobe and the sample valid in the same half-cycle. It then reads the result and follows with a second sample to show the new setting took effect. Saturation at both ends in both codings is reached through table vectors that pair extreme raw samples with the largest positive and negative offsets.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
    typedef enum logic {
        PWR_ACTIVE = 1'b0,
        PWR_SLEEP  = 1'b1
    } pwr_state_e;

    typedef enum logic [1:0] {
        REG_RESULT = 2'd0,
        REG_GAIN   = 2'd1,
        REG_OFFSET = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cvr_sample_path.sv
module cvr_sample_path #(
    parameter int DATA_W = 14,
    parameter int OFFS_W = 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [OFFS_W-1:0] offs,
    input  logic              offs_en,
    input  logic              fmt_twos,
    output logic [DATA_W-1:0] coded
);
    localparam int SUM_W = DATA_W + 2;

    logic [SUM_W-1:0]  raw_x;
    logic [SUM_W-1:0]  off_x;
    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] sat;

    always_comb begin
        raw_x = {2'b00, raw};
        off_x = offs_en ? {{(SUM_W-OFFS_W){offs[OFFS_W-1]}}, offs} : '0;
        sum   = raw_x + off_x;
        // negative sum clamps low, a carry into bit DATA_W clamps high
        if (sum[SUM_W-1]) begin
            sat = '0;
        end else if (sum[DATA_W]) begin
            sat = '1;
        end else begin
            sat = sum[DATA_W-1:0];
        end
        coded = sat ^ {fmt_twos, {(DATA_W-1){1'b0}}};
    end
endmodule

// File: rtl/cvr_result_latch.sv
module cvr_result_latch #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] result
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (take) begin
            result <= value;
        end
    end
endmodule

// File: rtl/cvr_ctrl_regs.sv
module cvr_ctrl_regs
    import cvr_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int GAIN_W = 3,
    parameter int OFFS_W = 8,
    parameter int TM_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] host_rdata,
    output logic [GAIN_W-1:0] gain_code,
    output logic [OFFS_W-1:0] offs,
    output logic              offs_en,
    output logic              fmt_twos,
    output logic              pwr_down,
    output logic              ref_sel,
    output logic [TM_W-1:0]   test_mode,
    output logic              test_active
);
    localparam int PD_BIT  = DATA_W - 1;
    localparam int REF_BIT = DATA_W - 2;
    localparam int FMT_BIT = DATA_W - 3;
    localparam int TM_LSB  = FMT_BIT - TM_W;
    localparam int OEN_BIT = TM_LSB - 1;

    reg_sel_e    sel;
    logic        wr_res, wr_gain, wr_offs, wr_ctrl, swrst;
    pwr_state_e  state_q, state_d;
    logic [GAIN_W-1:0] gain_q;
    logic [OFFS_W-1:0] offs_q;
    logic              ref_q, fmt_q, oen_q;
    logic [TM_W-1:0]   tm_q;
    logic [DATA_W-1:0] ctrl_rd;

    always_comb begin
        sel     = reg_sel_e'(host_addr);
        wr_res  = host_we && (sel == REG_RESULT);
        wr_gain = host_we && (sel == REG_GAIN);
        wr_offs = host_we && (sel == REG_OFFSET);
        wr_ctrl = host_we && (sel == REG_CTRL);
        swrst   = wr_res && host_wdata[0];
    end

    // power state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enter_sleep and wake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ACTIVE: if (!swrst && wr_ctrl && host_wdata[PD_BIT]) state_d = PWR_SLEEP;
            PWR_SLEEP:  if (swrst || (wr_ctrl && !host_wdata[PD_BIT])) state_d = PWR_ACTIVE;
        endcase
    end

    // settings registers
    always_ff @(posedge clk) begin
        if (!rst_n || swrst) begin
            gain_q <= '0;
            offs_q <= '0;
            ref_q  <= 1'b0;
            fmt_q  <= 1'b0;
            tm_q   <= '0;
            oen_q  <= 1'b0;
        end else begin
            if (wr_gain) gain_q <= host_wdata[GAIN_W-1:0];
            if (wr_offs) offs_q <= host_wdata[OFFS_W-1:0];
            if (wr_ctrl) begin
                ref_q <= host_wdata[REF_BIT];
                fmt_q <= host_wdata[FMT_BIT];
                tm_q  <= host_wdata[TM_LSB +: TM_W];
                oen_q <= host_wdata[OEN_BIT];
            end
        end
    end

    // outputs
    always_comb begin
        pwr_down    = (state_q == PWR_SLEEP);
        gain_code   = gain_q;
        offs        = offs_q;
        offs_en     = oen_q;
        fmt_twos    = fmt_q;
        ref_sel     = ref_q;
        test_mode   = tm_q;
        test_active = (tm_q[1:0] != 2'b00);

        ctrl_rd                   = '0;
        ctrl_rd[PD_BIT]           = pwr_down;
        ctrl_rd[REF_BIT]          = ref_q;
        ctrl_rd[FMT_BIT]          = fmt_q;
        ctrl_rd[TM_LSB +: TM_W]   = tm_q;
        ctrl_rd[OEN_BIT]          = oen_q;

        unique case (sel)
            REG_RESULT: host_rdata = result;
            REG_GAIN:   host_rdata = {{(DATA_W-GAIN_W){1'b0}}, gain_q};
            REG_OFFSET: host_rdata = {{(DATA_W-OFFS_W){1'b0}}, offs_q};
            REG_CTRL:   host_rdata = ctrl_rd;
        endcase
    end
endmodule

// File: rtl/adc_conv_regbank.sv
module adc_conv_regbank #(
    parameter int DATA_W = 14,
    parameter int GAIN_W = 3,
    parameter int OFFS_W = 8,
    parameter int TM_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic [GAIN_W-1:0] gain_code,
    output logic              pwr_down,
    output logic              ref_sel,
    output logic [TM_W-1:0]   test_mode,
    output logic              test_active
);
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] coded;
    logic [OFFS_W-1:0] offs;
    logic              offs_en, fmt_twos, take;

    cvr_ctrl_regs #(
        .DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFFS_W(OFFS_W), .TM_W(TM_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .result(result_q), .host_rdata(host_rdata),
        .gain_code(gain_code), .offs(offs), .offs_en(offs_en),
        .fmt_twos(fmt_twos), .pwr_down(pwr_down), .ref_sel(ref_sel),
        .test_mode(test_mode), .test_active(test_active)
    );

    cvr_sample_path #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) path_i (
        .raw(smp_data), .offs(offs), .offs_en(offs_en),
        .fmt_twos(fmt_twos), .coded(coded)
    );

    assign take = smp_valid && !pwr_down;

    cvr_result_latch #(.DATA_W(DATA_W)) res_i (
        .clk(clk), .rst_n(rst_n), .take(take), .value(coded), .result(result_q)
    );
endmodule

// File: rtl/cvr_checker.sv
module cvr_checker #(
    parameter int DATA_W = 14,
    parameter int GAIN_W = 3,
    parameter int TM_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              smp_valid,
    input logic [GAIN_W-1:0] gain_code,
    input logic              pwr_down,
    input logic              ref_sel,
    input logic [TM_W-1:0]   test_mode,
    input logic              test_active,
    input logic [DATA_W-1:0] result_q
);
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(result_q)); // R10
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && host_wdata[0])
        |=> (gain_code == '0 && !pwr_down && !ref_sel && test_mode == '0)); // R3
    AST_RESULT_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && !smp_valid) |=> $stable(result_q)); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd3) |-> (host_rdata[6:0] == 7'd0)); // R1
    AST_NORMAL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 3'd0 || test_mode == 3'd4) |-> !test_active); // R11
    AST_GAIN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd1) |-> (host_rdata == {{(DATA_W-GAIN_W){1'b0}}, gain_code})); // R5
endmodule

bind adc_conv_regbank cvr_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .TM_W(TM_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .smp_valid(smp_valid),
    .gain_code(gain_code), .pwr_down(pwr_down), .ref_sel(ref_sel),
    .test_mode(test_mode), .test_active(test_active), .result_q(result_q)
);

// File: tb/adc_conv_regbank_tb_top.sv
`timescale 1ns/1ps
module adc_conv_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [13:0] host_wdata = '0;
    logic [13:0] host_rdata;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic [2:0]  gain_code;
    logic        pwr_down, ref_sel, test_active;
    logic [2:0]  test_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_conv_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .gain_code(gain_code), .pwr_down(pwr_down),
        .ref_sel(ref_sel), .test_mode(test_mode), .test_active(test_active)
    );

    // {offset_en, offset[7:0], fmt, raw[13:0], expected[13:0]}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 14'h1234, 14'h1234},  // R6
        {1'b1, 8'h10, 1'b0, 14'h1234, 14'h1244},  // R7
        {1'b1, 8'hF0, 1'b0, 14'h0005, 14'h0000},  // R8 low
        {1'b1, 8'h7F, 1'b0, 14'h3FF0, 14'h3FFF},  // R8 high
        {1'b0, 8'h7F, 1'b1, 14'h0000, 14'h2000},  // R9
        {1'b0, 8'h00, 1'b1, 14'h3FFF, 14'h1FFF},  // R9
        {1'b1, 8'h80, 1'b1, 14'h2080, 14'h0000},  // R7 R9
        {1'b1, 8'h80, 1'b1, 14'h0010, 14'h2000},  // R9 sat min
        {1'b1, 8'h7F, 1'b1, 14'h3FFF, 14'h1FFF},  // R9 sat max
        {1'b1, 8'hFF, 1'b0, 14'h2000, 14'h1FFF}   // R7
    };

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [13:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic smp(input logic [13:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [13:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    initial begin
        logic [13:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R2 reset readback", v, 14'h0000);
        end
        check("R2 pwr_down", {13'd0, pwr_down}, 14'd0);

        // R1 R5 readback masking
        wr(2'd1, 14'h3FFF);
        rd(2'd1, v); check("R5 gain readback", v, 14'h0007);
        check("R5 gain_code", {11'd0, gain_code}, 14'd7);
        wr(2'd2, 14'h3FAB);
        rd(2'd2, v); check("R1 offset readback", v, 14'h00AB);
        wr(2'd3, 14'h3FFF);
        rd(2'd3, v); check("R1 control readback", v, 14'h3F80);
        check("R10 pwr_down set", {13'd0, pwr_down}, 14'd1);
        check("R11 ref_sel", {13'd0, ref_sel}, 14'd1);

        // R10 samples ignored while asleep
        smp(14'h0ABC);
        rd(2'd0, v); check("R10 result held", v, 14'h0000);
        wr(2'd3, 14'h0000);
        check("R10 woke", {13'd0, pwr_down}, 14'd0);
        smp(14'h0ABC);
        rd(2'd0, v); check("R10 sample accepted", v, 14'h0ABC);

        // R11 test codes
        for (int t = 0; t < 8; t++) begin
            wr(2'd3, 14'(t << 8));
            check("R11 test_mode", {11'd0, test_mode}, 14'(t));
            check("R11 test_active", {13'd0, test_active}, (t == 0 || t == 4) ? 14'd0 : 14'd1);
        end

        // vector table: R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(2'd2, {6'd0, VEC[i][36:29]});
            wr(2'd3, {2'b00, VEC[i][28], 3'b000, VEC[i][37], 7'd0});
            smp(VEC[i][27:14]);
            rd(2'd0, v);
            check("R6-R9 vector", v, VEC[i][13:0]);
        end

        // R12 same-edge collision: old format used
        wr(2'd3, 14'h0000);
        @(negedge clk);
        host_we = 1'b1; host_addr = 2'd3; host_wdata = 14'h0800;
        smp_valid = 1'b1; smp_data = 14'h0100;
        @(negedge clk);
        host_we = 1'b0; smp_valid = 1'b0;
        rd(2'd0, v); check("R12 old setting", v, 14'h0100);
        smp(14'h0100);
        rd(2'd0, v); check("R12 new setting", v, 14'h2100);

        // R3 R4: bit0 clear is no-op, bit0 set soft resets
        wr(2'd1, 14'h0005);
        wr(2'd3, 14'h2000);
        wr(2'd0, 14'h3FFE);
        rd(2'd0, v); check("R4 result untouched", v, 14'h2100);
        rd(2'd1, v); check("R3 no reset on bit0=0", v, 14'h0005);
        wr(2'd0, 14'h0001);
        rd(2'd1, v); check("R3 gain cleared", v, 14'h0000);
        rd(2'd2, v); check("R3 offset cleared", v, 14'h0000);
        rd(2'd3, v); check("R3 control cleared", v, 14'h0000);
        rd(2'd0, v); check("R4 result kept by soft reset", v, 14'h2100);

        // R2 hardware reset clears result
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, v); check("R2 result cleared", v, 14'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule